// File: doc/BRIEF.md
# Latched-Upper Program Counter

This block holds the program counter for a byte-addressed instruction memory with a 21-bit address space. Instructions are two bytes wide, so the counter is always even. Each cycle it either holds, advances by one instruction, advances by two instructions to skip one, or loads an absolute target.

Only the least significant byte of the counter is visible to software as a data register. A write to that byte reloads the whole counter. The new value is built from the written byte and two holding registers: one for bits 15..8 and one for bits 20..16. This is how computed branches work. Software adds a byte offset to the low byte and writes the sum back, and the counter jumps inside the region the holding registers select.

The holding registers change in only two ways. The data bus can write them directly, or a read of the low byte refreshes them from the live counter. A write to the low byte never touches them. A computed branch that is not preceded by a low-byte read therefore uses whatever upper bytes were captured earlier.

Top module: `lupc_counter`

## Requirements
- R1: While reset is asserted at a clock edge, the counter and both holding registers become 0.
- R2: With only `step_en` set, the counter advances by 2. The sum wraps modulo 2^21, so 0x1FFFFE steps to 0.
- R3: With `skip_en` set, the counter advances by 4, wrapping modulo 2^21. This holds whether or not `step_en` is also set.
- R4: With `jump_en` set, the counter loads `jump_addr` with bit 0 cleared. A jump takes priority over skip and step.
- R5: With `lo_wr_en` set, the counter becomes {upper holding register in bits 20..16, high holding register in bits 15..8, `lo_wr_data` with bit 0 cleared in bits 7..0}. A low-byte write takes priority over jump, skip and step.
- R6: A low-byte write leaves both holding registers unchanged. A second low-byte write therefore reuses the same upper bits.
- R7: When `lo_rd_en` is set, the holding registers take bits 15..8 and 20..16 of the counter value present before that clock edge. This also applies when a low-byte write occurs in the same cycle; that write still combines with the old holding values.
- R8: When `hi_hold_wr_en` or `up_hold_wr_en` is set, the matching holding register loads its write data. A direct write wins over a refresh in the same cycle.
- R9: With no request asserted, the counter keeps its value.
- R10: Bit 0 of the counter is 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance one instruction (+2) |
| skip_en | input | 1 | Advance two instructions (+4) |
| jump_en | input | 1 | Load absolute target |
| jump_addr | input | 21 | Absolute target (bit 0 ignored) |
| lo_wr_en | input | 1 | Write to the low counter byte |
| lo_wr_data | input | 8 | Low byte write value |
| lo_rd_en | input | 1 | Low byte read strobe; refreshes the holding registers |
| hi_hold_wr_en | input | 1 | Direct write of the bits 15..8 holding register |
| hi_hold_wr_data | input | 8 | Value for the bits 15..8 holding register |
| up_hold_wr_en | input | 1 | Direct write of the bits 20..16 holding register |
| up_hold_wr_data | input | 5 | Value for the bits 20..16 holding register |
| pc_o | output | 21 | Current counter |

## Verification
The bench builds the block with its default widths: a 21-bit address and 8-bit bytes, which gives a 5-bit upper holding register. With these widths a single jump to 0x1FFFFE puts the wrap of both the step and the skip adders within reach in a few cycles. The 5-bit upper register is narrow enough that patterns in bits 20..16 can be seen directly in the counter after a computed branch. Stale and refreshed holding values are told apart by placing the counter in one region and the holding registers in another before each low-byte write.

// File: rtl/lupc_pkg.sv
// Package: shared selector encoding for the latched-upper program counter.
// Assumes: nothing beyond IEEE 1800-2017.
package lupc_pkg;

    // Which source feeds the counter register on the next edge.
    typedef enum logic [2:0] {
        SEL_HOLD = 3'd0,
        SEL_STEP = 3'd1,
        SEL_SKIP = 3'd2,
        SEL_JUMP = 3'd3,
        SEL_LOWR = 3'd4
    } pc_sel_e;

    localparam int unsigned INSN_BYTES = 2;

endpackage

// File: rtl/lupc_hold_reg.sv
// Module: one holding register for an upper slice of the counter.
// Loads from the data bus on a direct write. Otherwise refreshes from the
// live counter slice on a low-byte read. Otherwise keeps its value.
// Assumes: synchronous active-low reset; a direct write beats a refresh.
module lupc_hold_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         refresh_en,
    input  logic [W-1:0] live_slice,
    output logic [W-1:0] hold_q
);

    // Holding register update: reset, direct write, refresh, keep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_en) begin
            hold_q <= wr_data;
        end else if (refresh_en) begin
            hold_q <= live_slice;
        end
    end

endmodule

// File: rtl/lupc_next.sv
// Module: next-counter selector and adders.
// Priority: low-byte write > jump > skip > step > hold.
// Assumes: all arithmetic wraps at the address width; outputs are even.
module lupc_next
    import lupc_pkg::*;
#(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned UP_W  = ADDR_W - 2 * BYTE_W
) (
    input  logic              step_en,
    input  logic              skip_en,
    input  logic              jump_en,
    input  logic [ADDR_W-1:0] jump_addr,
    input  logic              lo_wr_en,
    input  logic [BYTE_W-1:0] lo_wr_data,
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [BYTE_W-1:0] hold_hi,
    input  logic [UP_W-1:0]   hold_up,
    output pc_sel_e           sel,
    output logic [ADDR_W-1:0] pc_d
);

    localparam logic [ADDR_W-1:0] STEP_INC = ADDR_W'(INSN_BYTES);
    localparam logic [ADDR_W-1:0] SKIP_INC = ADDR_W'(2 * INSN_BYTES);

    logic [ADDR_W-1:0] lowr_val;
    logic [ADDR_W-1:0] jump_val;

    // Operand forming: splice the holding registers, clear bit 0.
    always_comb begin
        lowr_val = {hold_up, hold_hi, lo_wr_data & ~BYTE_W'(1)};
        jump_val = jump_addr & ~ADDR_W'(1);
    end

    // Source priority decode.
    always_comb begin
        if (lo_wr_en)     sel = SEL_LOWR;
        else if (jump_en) sel = SEL_JUMP;
        else if (skip_en) sel = SEL_SKIP;
        else if (step_en) sel = SEL_STEP;
        else              sel = SEL_HOLD;
    end

    // Next value mux.
    always_comb begin
        unique case (sel)
            SEL_LOWR: pc_d = lowr_val;
            SEL_JUMP: pc_d = jump_val;
            SEL_SKIP: pc_d = pc_q + SKIP_INC;
            SEL_STEP: pc_d = pc_q + STEP_INC;
            default:  pc_d = pc_q;
        endcase
    end

endmodule

// File: rtl/lupc_counter.sv
// Module: top of the latched-upper program counter.
// Holds the counter and two holding registers for its upper slices.
// A low-byte write rebuilds the counter from the holding registers.
// A low-byte read refreshes them from the live counter.
// Assumes: ADDR_W > 2*BYTE_W; synchronous active-low reset.
module lupc_counter #(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned UP_W  = ADDR_W - 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              skip_en,
    input  logic              jump_en,
    input  logic [ADDR_W-1:0] jump_addr,
    input  logic              lo_wr_en,
    input  logic [BYTE_W-1:0] lo_wr_data,
    input  logic              lo_rd_en,
    input  logic              hi_hold_wr_en,
    input  logic [BYTE_W-1:0] hi_hold_wr_data,
    input  logic              up_hold_wr_en,
    input  logic [UP_W-1:0]   up_hold_wr_data,
    output logic [ADDR_W-1:0] pc_o
);

    logic [ADDR_W-1:0]      pc_q;
    logic [ADDR_W-1:0]      pc_d;
    logic [BYTE_W-1:0]      hold_hi_q;
    logic [UP_W-1:0]        hold_up_q;
    lupc_pkg::pc_sel_e      sel;

    lupc_hold_reg #(.W(BYTE_W)) u_hold_hi (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (hi_hold_wr_en),
        .wr_data    (hi_hold_wr_data),
        .refresh_en (lo_rd_en),
        .live_slice (pc_q[2*BYTE_W-1:BYTE_W]),
        .hold_q     (hold_hi_q)
    );

    lupc_hold_reg #(.W(UP_W)) u_hold_up (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (up_hold_wr_en),
        .wr_data    (up_hold_wr_data),
        .refresh_en (lo_rd_en),
        .live_slice (pc_q[ADDR_W-1:2*BYTE_W]),
        .hold_q     (hold_up_q)
    );

    lupc_next #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_next (
        .step_en    (step_en),
        .skip_en    (skip_en),
        .jump_en    (jump_en),
        .jump_addr  (jump_addr),
        .lo_wr_en   (lo_wr_en),
        .lo_wr_data (lo_wr_data),
        .pc_q       (pc_q),
        .hold_hi    (hold_hi_q),
        .hold_up    (hold_up_q),
        .sel        (sel),
        .pc_d       (pc_d)
    );

    // Counter register: clear on reset, else take the selected next value.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/lupc_counter_chk.sv
// Module: assertion checker for lupc_counter, attached by bind.
// Assumes: observes ports plus the two holding registers.
module lupc_counter_chk #(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned UP_W  = ADDR_W - 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_en,
    input logic              skip_en,
    input logic              jump_en,
    input logic [ADDR_W-1:0] jump_addr,
    input logic              lo_wr_en,
    input logic [BYTE_W-1:0] lo_wr_data,
    input logic              lo_rd_en,
    input logic              hi_hold_wr_en,
    input logic              up_hold_wr_en,
    input logic [ADDR_W-1:0] pc_o,
    input logic [BYTE_W-1:0] hold_hi_q,
    input logic [UP_W-1:0]   hold_up_q
);

    AST_STEP_ADDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !skip_en && !jump_en && !lo_wr_en) |=> pc_o == $past(pc_o) + ADDR_W'(2)); // R2
    AST_SKIP_ADDS_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_en && !jump_en && !lo_wr_en) |=> pc_o == $past(pc_o) + ADDR_W'(4)); // R3
    AST_JUMP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_en && !lo_wr_en) |=> pc_o[ADDR_W-1:1] == $past(jump_addr[ADDR_W-1:1])); // R4
    AST_LOWR_SPLICE: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr_en |=> (pc_o[ADDR_W-1:BYTE_W] == $past({hold_up_q, hold_hi_q}))
                  && (pc_o[BYTE_W-1:1] == $past(lo_wr_data[BYTE_W-1:1]))); // R5
    AST_LOWR_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr_en && !lo_rd_en && !hi_hold_wr_en && !up_hold_wr_en)
        |=> $stable(hold_hi_q) && $stable(hold_up_q)); // R6
    AST_READ_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_rd_en && !hi_hold_wr_en && !up_hold_wr_en)
        |=> {hold_up_q, hold_hi_q} == $past(pc_o[ADDR_W-1:BYTE_W])); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !skip_en && !jump_en && !lo_wr_en) |=> $stable(pc_o)); // R9
    AST_EVEN_PC: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pc_o[0] == 1'b0); // R10

endmodule

bind lupc_counter lupc_counter_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_en       (step_en),
    .skip_en       (skip_en),
    .jump_en       (jump_en),
    .jump_addr     (jump_addr),
    .lo_wr_en      (lo_wr_en),
    .lo_wr_data    (lo_wr_data),
    .lo_rd_en      (lo_rd_en),
    .hi_hold_wr_en (hi_hold_wr_en),
    .up_hold_wr_en (up_hold_wr_en),
    .pc_o          (pc_o),
    .hold_hi_q     (hold_hi_q),
    .hold_up_q     (hold_up_q)
);

// File: tb/lupc_counter_tb.sv
// Bench: behavioural reference model compared with the counter on every clock.
module lupc_counter_tb;

    localparam int ADDR_W = 21;
    localparam int BYTE_W = 8;
    localparam int UP_W   = ADDR_W - 2 * BYTE_W;
    localparam int MASK   = (1 << ADDR_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              step_en, skip_en, jump_en, lo_wr_en, lo_rd_en;
    logic              hi_hold_wr_en, up_hold_wr_en;
    logic [ADDR_W-1:0] jump_addr;
    logic [BYTE_W-1:0] lo_wr_data, hi_hold_wr_data;
    logic [UP_W-1:0]   up_hold_wr_data;
    logic [ADDR_W-1:0] pc_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference state.
    int m_pc = 0;
    int m_hi = 0;
    int m_up = 0;

    always #2 clk = ~clk;

    lupc_counter u_dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .skip_en(skip_en),
        .jump_en(jump_en), .jump_addr(jump_addr), .lo_wr_en(lo_wr_en),
        .lo_wr_data(lo_wr_data), .lo_rd_en(lo_rd_en),
        .hi_hold_wr_en(hi_hold_wr_en), .hi_hold_wr_data(hi_hold_wr_data),
        .up_hold_wr_en(up_hold_wr_en), .up_hold_wr_data(up_hold_wr_data),
        .pc_o(pc_o)
    );

    task automatic clear_inputs();
        step_en = 0; skip_en = 0; jump_en = 0; lo_wr_en = 0; lo_rd_en = 0;
        hi_hold_wr_en = 0; up_hold_wr_en = 0;
        jump_addr = '0; lo_wr_data = '0; hi_hold_wr_data = '0; up_hold_wr_data = '0;
    endtask

    // One clock: predict, let the edge pass, compare away from the edge.
    task automatic tick(input string req);
        int n_pc, n_hi, n_up;
        n_pc = m_pc; n_hi = m_hi; n_up = m_up;
        if (!rst_n) begin
            n_pc = 0; n_hi = 0; n_up = 0;
        end else begin
            if (lo_wr_en)     n_pc = (m_up << 16) | (m_hi << 8) | (int'(lo_wr_data) & 'hFE);
            else if (jump_en) n_pc = int'(jump_addr) & ~1;
            else if (skip_en) n_pc = (m_pc + 4) & MASK;
            else if (step_en) n_pc = (m_pc + 2) & MASK;
            if (hi_hold_wr_en)  n_hi = int'(hi_hold_wr_data);
            else if (lo_rd_en)  n_hi = (m_pc >> 8) & 'hFF;
            if (up_hold_wr_en)  n_up = int'(up_hold_wr_data);
            else if (lo_rd_en)  n_up = (m_pc >> 16) & 'h1F;
        end
        @(posedge clk);
        #1;
        m_pc = n_pc; m_hi = n_hi; m_up = n_up;
        total++;
        if (int'(pc_o) != m_pc) begin
            bad++;
            $display("FAIL %s: pc actual=%06h expected=%06h", req, pc_o, m_pc);
        end
        total++;
        if (pc_o[0] !== 1'b0) begin
            bad++;
            $display("FAIL R10: pc bit0 actual=%0b expected=0", pc_o[0]);
        end
        clear_inputs();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst_n = 0;
        #1;
        tick("R1"); tick("R1");
        rst_n = 1;
        // R1: a low write of 0 exposes zero holding registers.
        lo_wr_en = 1; lo_wr_data = 8'h00; tick("R1");
        // R9: idle holds.
        tick("R9");
        // R2: sequential steps.
        for (int i = 0; i < 5; i++) begin step_en = 1; tick("R2"); end
        // R3: skip alone and skip with step.
        skip_en = 1; tick("R3");
        skip_en = 1; step_en = 1; tick("R3");
        // R4: odd target with bit 0 cleared, beating skip.
        jump_en = 1; jump_addr = 21'h12345; skip_en = 1; tick("R4");
        tick("R9");
        // R2 wrap at top.
        jump_en = 1; jump_addr = 21'h1FFFFE; tick("R4");
        step_en = 1; tick("R2");
        // R3 wrap at top.
        jump_en = 1; jump_addr = 21'h1FFFFC; tick("R4");
        skip_en = 1; tick("R3");
        // R8: direct loads of the holding registers, then splice.
        hi_hold_wr_en = 1; hi_hold_wr_data = 8'hA5; up_hold_wr_en = 1; up_hold_wr_data = 5'h13; tick("R8");
        lo_wr_en = 1; lo_wr_data = 8'h3B; jump_en = 1; jump_addr = 21'h00100; tick("R5");
        // R6: move counter away, computed branch still uses stale holding values.
        jump_en = 1; jump_addr = 21'h0C7F0; tick("R4");
        lo_wr_en = 1; lo_wr_data = 8'(int'(pc_o[7:0]) + 6); tick("R6");
        // R7: read then computed branch picks up live upper bytes.
        jump_en = 1; jump_addr = 21'h1E2F40; tick("R4");
        lo_rd_en = 1; step_en = 1; tick("R7");
        lo_wr_en = 1; lo_wr_data = 8'(int'(pc_o[7:0]) + 8); tick("R7");
        // R7: read and write in the same cycle.
        jump_en = 1; jump_addr = 21'h04410; tick("R4");
        lo_rd_en = 1; lo_wr_en = 1; lo_wr_data = 8'h20; tick("R7");
        lo_wr_en = 1; lo_wr_data = 8'h30; tick("R7");
        // R8: direct write beats a refresh in the same cycle.
        jump_en = 1; jump_addr = 21'h155500; tick("R4");
        lo_rd_en = 1; hi_hold_wr_en = 1; hi_hold_wr_data = 8'h0F; tick("R8");
        lo_wr_en = 1; lo_wr_data = 8'h44; tick("R8");
        lo_rd_en = 1; up_hold_wr_en = 1; up_hold_wr_data = 5'h02; tick("R8");
        lo_wr_en = 1; lo_wr_data = 8'h46; tick("R8");
        // R5: low write beats step and skip.
        lo_wr_en = 1; lo_wr_data = 8'hFF; step_en = 1; skip_en = 1; tick("R5");
        // R1: reset in mid run clears everything.
        rst_n = 0; step_en = 1; tick("R1");
        rst_n = 1;
        lo_wr_en = 1; lo_wr_data = 8'h10; tick("R1");
        for (int i = 0; i < 4; i++) begin step_en = 1; tick("R2"); tick("R9"); end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule